// File: doc/BRIEF.md
# Cycle-Stealing DMA Channel

This block copies a run of bytes from a peripheral into a buffer in main store. After setup the processor takes no further part. Software writes the first buffer location into an address counter and the number of bytes into a remaining-count register, and then issues a start command. From that point the channel works on its own. It accepts a byte from the device and parks it in a single holding slot. It then asks the memory arbiter for one write cycle. When a cycle is granted, the byte goes to the address held in the counter.

Each granted cycle is taken from the processor's memory access. After every byte written, the address steps up by one and the remaining count steps down by one. The write that empties the count ends the run and posts a done flag. That flag stays up until software clears it or starts a new run.

Top module: `cyc_steal_dma`

## Requirements
- R1: After synchronous reset, `stat_busy`, `stat_done`, `mem_req` and `dev_ack` are 0, and `stat_addr` and `stat_count` are 0.
- R2: While idle, a register write with select 0 loads the address counter from `cfg_wdata`, and select 1 loads the remaining count from the low `CNT_W` bits. The new value is visible on `stat_addr` or `stat_count` after the clock edge.
- R3: A start command (select 2) issued while idle with a nonzero count raises `stat_busy` and lowers `stat_done` at the next edge.
- R4: `dev_ack` is 1 exactly while the channel is busy and its holding slot is empty. A byte is taken on an edge where `dev_valid` and `dev_ack` are both 1.
- R5: While a byte is held, `mem_req` is 1, `mem_addr` equals the address counter, `mem_wdata` equals the held byte, and `dev_ack` is 0. With no byte held, `mem_req` is 0.
- R6: On an edge where `mem_req` and `mem_gnt` are both 1, the write completes. The address counter rises by 1 (wrapping at the top of its width), the remaining count falls by 1, and the holding slot empties.
- R7: When the write that brings the count from 1 to 0 completes, `stat_busy` falls and `stat_done` rises on that same edge.
- R8: A start command with a remaining count of 0 sets `stat_done` at the next edge and leaves `stat_busy` at 0.
- R9: `stat_done` holds its value through other register writes. It clears on a clear command (select 3) or on a new start with a nonzero count.
- R10: Every register write made while `stat_busy` is 1 is ignored: address, count, start and clear have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 address, 1 count, 2 start, 3 clear done |
| cfg_wdata | input | ADDR_W | Write data |
| stat_busy | output | 1 | Transfer in progress |
| stat_done | output | 1 | Transfer finished flag |
| stat_addr | output | ADDR_W | Current address counter |
| stat_count | output | CNT_W | Remaining byte count |
| dev_valid | input | 1 | Device presents a byte |
| dev_data | input | 8 | Byte from device |
| dev_ack | output | 1 | Channel can accept a byte |
| mem_req | output | 1 | Request for a memory write cycle |
| mem_gnt | input | 1 | Arbiter grants the cycle |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 8 | Write data |

## Verification
The main transfer runs from a table of runs. The runs differ in start address, length, grant latency and device latency. An immediate grant with a ready device shows the fastest turn of the holding slot. Slow grants with a fast device prove that the device is held off while a byte waits. A slow device with fast grants shows that the channel idles cleanly between bytes. A run that starts just below the top of the address space checks the counter wrap. Every write is matched against the expected address and data, in order. Directed cases cover a start with zero length, the life of the done flag, and writes issued during a run that must leave the address, count and flags untouched.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SEL_ADDR     = 2'd0,
        SEL_COUNT    = 2'd1,
        SEL_GO       = 2'd2,
        SEL_ACK_DONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic  full;
        byte_t data;
    } hold_t;

    function automatic logic is_last_unit(input logic [31:0] remaining);
        return remaining == 32'd1;
    endfunction

endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              fire,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(1);

    logic     idle_wr;
    cfg_sel_e sel;

    assign idle_wr = cfg_we && !busy;
    assign sel     = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else if (busy) begin
            if (fire) begin
                addr <= addr + ADDR_STEP;
                cnt  <= cnt - CNT_STEP;
                if (is_last_unit(32'(cnt))) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end else if (idle_wr) begin
            case (sel)
                SEL_ADDR:  addr <= cfg_wdata;
                SEL_COUNT: cnt  <= cfg_wdata[CNT_W-1:0];
                SEL_GO: begin
                    if (cnt == '0) begin
                        done <= 1'b1;
                    end else begin
                        done <= 1'b0;
                        busy <= 1'b1;
                    end
                end
                default:   done <= 1'b0;
            endcase
        end
    end

    // R7
    last_write_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && fire && cnt == CNT_STEP) |=> (done && !busy));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && fire) |=> (addr == $past(addr) + ADDR_STEP && cnt == $past(cnt) - CNT_STEP));

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_we && !fire) |=> (addr == $past(addr) && cnt == $past(cnt) && busy));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: rtl/dma_hold.sv
module dma_hold
    import dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  byte_t take_data,
    input  logic  drain,
    output hold_t slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (take) begin
            slot.full <= 1'b1;
            slot.data <= take_data;
        end else if (drain) begin
            slot.full <= 1'b0;
        end
    end

    // R5
    held_byte_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (slot.full && !drain) |=> (slot.full && $stable(slot.data)));

    // R4
    no_take_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        slot.full |-> !take);

endmodule

// File: rtl/cyc_steal_dma.sv
module cyc_steal_dma
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              stat_busy,
    output logic              stat_done,
    output logic [ADDR_W-1:0] stat_addr,
    output logic [CNT_W-1:0]  stat_count,
    input  logic              dev_valid,
    input  logic [7:0]        dev_data,
    output logic              dev_ack,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    logic  busy, done, take, fire;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    hold_t slot;

    assign dev_ack = busy && !slot.full;
    assign take    = dev_valid && dev_ack;
    assign fire    = slot.full && mem_gnt;

    dma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .fire      (fire),
        .addr      (addr),
        .cnt       (cnt),
        .busy      (busy),
        .done      (done)
    );

    dma_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_data (dev_data),
        .drain     (fire),
        .slot      (slot)
    );

    assign mem_req    = slot.full;
    assign mem_addr   = addr;
    assign mem_wdata  = slot.data;
    assign stat_busy  = busy;
    assign stat_done  = done;
    assign stat_addr  = addr;
    assign stat_count = cnt;

    // R5
    req_blocks_ack_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !dev_ack);

    // R5
    req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> stat_busy);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_done && !(cfg_we && (cfg_sel == 2'd3 || cfg_sel == 2'd2))) |=> stat_done);

endmodule

// File: tb/cyc_steal_dma_tb.sv
module cyc_steal_dma_tb;

    localparam int AW = 16;
    localparam int CW = 12;

    typedef struct packed {
        logic [15:0] base;
        logic [11:0] len;
        logic [3:0]  gdly;
        logic [3:0]  ddly;
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'h0100, 12'd5, 4'd0, 4'd0, 8'h10},
        '{16'h2000, 12'd1, 4'd3, 4'd0, 8'hA5},
        '{16'h00FE, 12'd4, 4'd0, 4'd5, 8'h3C},
        '{16'hFFFE, 12'd4, 4'd2, 4'd2, 8'hF0},
        '{16'h1234, 12'd9, 4'd1, 4'd3, 8'h01}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic stat_busy, stat_done, dev_ack, mem_req;
    logic [AW-1:0] stat_addr, mem_addr;
    logic [CW-1:0] stat_count;
    logic dev_valid = 1'b0;
    logic [7:0] dev_data = '0;
    logic mem_gnt = 1'b0;
    logic [7:0] mem_wdata;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cyc_steal_dma #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .stat_busy(stat_busy), .stat_done(stat_done),
        .stat_addr(stat_addr), .stat_count(stat_count),
        .dev_valid(dev_valid), .dev_data(dev_data), .dev_ack(dev_ack),
        .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic transfer(input logic [15:0] base, input int len,
                            input int gdly, input int ddly, input logic [7:0] seed);
        int n_in = 0;
        int n_out = 0;
        int gwait = 0;
        int dwait = 0;
        int guard = 0;
        logic wrong = 1'b0;
        while (n_out < len && guard < 2000) begin
            guard++;
            if (mem_req && dev_ack) wrong = 1'b1;
            if (mem_req && gwait >= gdly) begin
                mem_gnt = 1'b1;
                chk(mem_addr == AW'(base + n_out), "R5", "write address", mem_addr, AW'(base + n_out));
                chk(mem_wdata == 8'(seed + n_out), "R5", "write data", mem_wdata, 8'(seed + n_out));
                n_out++;
                gwait = 0;
            end else begin
                mem_gnt = 1'b0;
                if (mem_req) gwait++;
            end
            if (n_in < len && dwait >= ddly) begin
                dev_valid = 1'b1;
                dev_data  = 8'(seed + n_in);
                if (dev_ack) begin
                    n_in++;
                    dwait = 0;
                end
            end else begin
                dev_valid = 1'b0;
                dwait++;
            end
            @(negedge clk);
        end
        mem_gnt   = 1'b0;
        dev_valid = 1'b0;
        chk(!wrong, "R5", "dev_ack low while byte held", wrong, 0);
        chk(n_out == len, "R6", "writes completed", n_out, len);
        chk(stat_done && !stat_busy, "R7", "done set, busy clear at end",
            {stat_done, stat_busy}, 2'b10);
        chk(stat_addr == AW'(base + len), "R6", "final address", stat_addr, AW'(base + len));
        chk(stat_count == '0, "R6", "final count", stat_count, 0);
        chk(!dev_ack && !mem_req, "R4", "idle handshake after finish", {dev_ack, mem_req}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!stat_busy && !stat_done && !mem_req && !dev_ack, "R1", "flags after reset",
            {stat_busy, stat_done, mem_req, dev_ack}, 0);
        chk(stat_addr == '0 && stat_count == '0, "R1", "counters after reset",
            {stat_addr, stat_count}, 0);

        foreach (VECS[i]) begin
            cfg_write(2'd0, VECS[i].base);
            chk(stat_addr == VECS[i].base, "R2", "address load", stat_addr, VECS[i].base);
            cfg_write(2'd1, AW'(VECS[i].len));
            chk(stat_count == VECS[i].len, "R2", "count load", stat_count, VECS[i].len);
            cfg_write(2'd2, '0);
            chk(stat_busy && !stat_done, "R3", "busy after start", {stat_busy, stat_done}, 2'b10);
            chk(dev_ack, "R4", "ack with empty slot", dev_ack, 1);
            transfer(VECS[i].base, int'(VECS[i].len), int'(VECS[i].gdly),
                     int'(VECS[i].ddly), VECS[i].seed);
        end

        // R9 done survives an address write, then clears on the clear command
        cfg_write(2'd0, 16'h0400);
        chk(stat_done, "R9", "done kept over address write", stat_done, 1);
        cfg_write(2'd3, '0);
        chk(!stat_done, "R9", "done cleared by clear", stat_done, 0);

        // R8 zero-length start
        cfg_write(2'd1, '0);
        cfg_write(2'd2, '0);
        chk(stat_done && !stat_busy && !mem_req, "R8", "zero count start",
            {stat_done, stat_busy, mem_req}, 3'b100);

        // R10 writes during a run are ignored; R9 start clears done
        cfg_write(2'd1, 16'd3);
        cfg_write(2'd2, '0);
        chk(!stat_done && stat_busy, "R9", "new start clears done", {stat_done, stat_busy}, 2'b01);
        cfg_write(2'd0, 16'hBEEF);
        cfg_write(2'd1, 16'd7);
        cfg_write(2'd3, '0);
        cfg_write(2'd2, '0);
        chk(stat_addr == 16'h0400, "R10", "address write ignored while busy", stat_addr, 16'h0400);
        chk(stat_count == 12'd3, "R10", "count write ignored while busy", stat_count, 3);
        chk(stat_busy, "R10", "busy unchanged by writes", stat_busy, 1);
        transfer(16'h0400, 3, 1, 1, 8'h77);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule